// File: doc/BRIEF.md
# Program Counter Target Selector

This block works out where instruction fetch continues after the current instruction. For each cycle it takes the current program counter, a transfer-type code, an immediate target, a 16-bit pointer value, an extension register and a 12-bit signed relative offset. It returns the next program counter and a strobe that is high when the next program counter comes from a control transfer rather than from normal sequential flow.

Five kinds of flow are supported. Sequential flow steps one word, or two words for a two-word instruction. Absolute transfers load the immediate. Pointer transfers load the zero-extended 16-bit pointer. Extended pointer transfers place extension bits above the pointer so that they can reach past a 16-bit word space. Relative transfers add the sign-extended offset to the address of the following word.

The program counter counts instruction words. Its width is a parameter of at most 22 bits. Results are registered, so the next program counter and the strobe appear one clock after the inputs are presented. Instruction decode, condition evaluation and return-stack handling are not part of this block.

Top module: `pcsel_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `next_pc_o` = 0 and `taken_o` = 0.
- R2: `next_pc_o` and `taken_o` reflect the inputs that were present at the preceding rising edge (one cycle of latency).
- R3: Mode code 1 (absolute) gives `next_pc_o` = `imm_i`.
- R4: Mode code 2 (pointer) gives `next_pc_o` = `z_i`, zero-extended to the PC width.
- R5: Mode code 3 (extended pointer), with `HAS_EXT`=1, gives `next_pc_o` = {`ext_i`, `z_i`} truncated to the PC width. With the default width this means `ext_i` bits 5..0 sit above `z_i`, and `ext_i` bits 7..6 are dropped.
- R6: Mode code 4 (relative) gives `next_pc_o` = `pc_i` + sext(`rel_k_i`) + 1. `rel_k_i` is 12-bit two's complement, so offsets from -2048 to 2047 are covered.
- R7: Mode code 0 (sequential) gives `pc_i` + 1, or `pc_i` + 2 when `two_word_i` is 1.
- R8: Every sum wraps modulo 2^PC_W.
- R9: `taken_o` is 1 exactly for mode codes 1 to 4. Codes 5 to 7 behave as sequential flow.
- R10: `two_word_i` has no effect in mode codes 1 to 4.
- R11: With `HAS_EXT`=0, mode code 3 behaves as code 2 and `ext_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Transfer-type code |
| two_word_i | input | 1 | The current instruction occupies two words |
| pc_i | input | PC_W | Current program counter (word address) |
| imm_i | input | PC_W | Absolute target carried by the instruction |
| rel_k_i | input | REL_W | Signed relative offset |
| z_i | input | 16 | Pointer register value |
| ext_i | input | EXT_W | Extension register for extended pointer transfers |
| next_pc_o | output | PC_W | Registered next program counter |
| taken_o | output | 1 | Registered strobe, high for a control transfer |

## Verification
The assertions take for granted that every input is a known value at each sampled edge while reset is released, and that the input values can change on every cycle. They read the inputs through `$past`, so the stimulus changes the inputs only on the falling edge and keeps each value stable across the rising edge that captures it. The bench drives all eight mode codes, including the unused ones, together with offsets at both ends of the 12-bit range and program counters close to zero and close to the top of the address space. This exercises the wrap rule on every path without any input leaving its declared width.

// File: rtl/pcsel_pkg.sv
// Package: shared transfer-type codes for the program counter target selector.
// Assumes: codes 5..7 are not assigned and are treated as sequential flow.
package pcsel_pkg;

    typedef enum logic [2:0] {
        XFER_SEQ  = 3'd0,
        XFER_ABS  = 3'd1,
        XFER_PTR  = 3'd2,
        XFER_XPTR = 3'd3,
        XFER_REL  = 3'd4
    } xfer_e;

endpackage

// File: rtl/pcsel_step_add.sv
// Module: pcsel_step_add
// Adds a step to the current PC. The step is either the sign-extended
// relative offset plus one, or a fixed 1 or 2 for sequential flow.
// Assumes: the result wraps modulo 2^PC_W; REL_W >= 2.
module pcsel_step_add #(
    parameter int PC_W  = 22,
    parameter int REL_W = 12
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [REL_W-1:0] rel_k_i,
    input  logic             use_rel_i,
    input  logic             two_word_i,
    output logic [PC_W-1:0]  sum_o
);

    logic [PC_W-1:0] k_ext;
    logic [PC_W-1:0] step;

    // Widen or narrow the offset to the PC width, keeping its sign.
    generate
        if (PC_W > REL_W) begin : g_sext
            assign k_ext = {{(PC_W-REL_W){rel_k_i[REL_W-1]}}, rel_k_i};
        end else begin : g_trunc
            assign k_ext = rel_k_i[PC_W-1:0];
        end
    endgenerate

    // Pick the increment and form the modular sum.
    always_comb begin
        if (use_rel_i)
            step = k_ext + PC_W'(1);
        else if (two_word_i)
            step = PC_W'(2);
        else
            step = PC_W'(1);
        sum_o = pc_i + step;
    end

endmodule

// File: rtl/pcsel_ptr_tgt.sv
// Module: pcsel_ptr_tgt
// Forms the pointer-based target: the zero-extended pointer, or the extension
// bits stacked above the pointer when the extended variant is built in.
// Assumes: PC_W <= Z_W + EXT_W.
module pcsel_ptr_tgt #(
    parameter int PC_W    = 22,
    parameter int Z_W     = 16,
    parameter int EXT_W   = 8,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic [Z_W-1:0]   z_i,
    input  logic [EXT_W-1:0] ext_i,
    input  logic             use_ext_i,
    output logic [PC_W-1:0]  tgt_o
);

    localparam int WIDE_W = Z_W + EXT_W;

    logic [WIDE_W-1:0] z_wide;
    logic [WIDE_W-1:0] xz_wide;
    logic              unused_ptr;

    assign z_wide     = {{EXT_W{1'b0}}, z_i};
    assign xz_wide    = {ext_i, z_i};
    assign unused_ptr = ^{xz_wide, use_ext_i};

    // Choose the variant: extension-aware selection or plain pointer.
    generate
        if (HAS_EXT) begin : g_ext
            assign tgt_o = use_ext_i ? xz_wide[PC_W-1:0] : z_wide[PC_W-1:0];
        end else begin : g_noext
            assign tgt_o = z_wide[PC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pcsel_mux.sv
// Module: pcsel_mux
// Chooses the next-PC source from the transfer code and flags real transfers.
// Assumes: unassigned codes fall back to the sequential sum.
module pcsel_mux
    import pcsel_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic [2:0]      mode_i,
    input  logic [PC_W-1:0] sum_i,
    input  logic [PC_W-1:0] imm_i,
    input  logic [PC_W-1:0] ptr_i,
    output logic [PC_W-1:0] pc_o,
    output logic            taken_o
);

    // Route one source to the output according to the code.
    always_comb begin
        pc_o    = sum_i;
        taken_o = 1'b0;
        case (mode_i)
            XFER_ABS:  begin pc_o = imm_i; taken_o = 1'b1; end
            XFER_PTR,
            XFER_XPTR: begin pc_o = ptr_i; taken_o = 1'b1; end
            XFER_REL:  begin pc_o = sum_i; taken_o = 1'b1; end
            default:   begin pc_o = sum_i; taken_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pcsel_top.sv
// Module: pcsel_top
// Registered next-program-counter selector with sequential, absolute,
// pointer, extended pointer and relative modes.
// Assumes: inputs are valid every cycle; PC_W <= 16 + EXT_W and PC_W <= 22.
module pcsel_top
    import pcsel_pkg::*;
#(
    parameter int PC_W    = 22,
    parameter int REL_W   = 12,
    parameter int EXT_W   = 8,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             two_word_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  imm_i,
    input  logic [REL_W-1:0] rel_k_i,
    input  logic [15:0]      z_i,
    input  logic [EXT_W-1:0] ext_i,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             taken_o
);

    localparam int Z_W = 16;

    logic [PC_W-1:0] sum_w;
    logic [PC_W-1:0] ptr_w;
    logic [PC_W-1:0] sel_w;
    logic            take_w;
    logic            is_rel;
    logic            is_xptr;

    // Decode the two codes that steer the shared datapath pieces.
    always_comb begin
        is_rel  = (mode_i == XFER_REL);
        is_xptr = (mode_i == XFER_XPTR);
    end

    pcsel_step_add #(.PC_W(PC_W), .REL_W(REL_W)) u_add (
        .pc_i       (pc_i),
        .rel_k_i    (rel_k_i),
        .use_rel_i  (is_rel),
        .two_word_i (two_word_i),
        .sum_o      (sum_w)
    );

    pcsel_ptr_tgt #(.PC_W(PC_W), .Z_W(Z_W), .EXT_W(EXT_W), .HAS_EXT(HAS_EXT)) u_ptr (
        .z_i       (z_i),
        .ext_i     (ext_i),
        .use_ext_i (is_xptr),
        .tgt_o     (ptr_w)
    );

    pcsel_mux #(.PC_W(PC_W)) u_mux (
        .mode_i  (mode_i),
        .sum_i   (sum_w),
        .imm_i   (imm_i),
        .ptr_i   (ptr_w),
        .pc_o    (sel_w),
        .taken_o (take_w)
    );

    // Capture the selected target; clear on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o <= '0;
            taken_o   <= 1'b0;
        end else begin
            next_pc_o <= sel_w;
            taken_o   <= take_w;
        end
    end

endmodule

// File: rtl/pcsel_chk.sv
// Module: pcsel_chk
// Port-level temporal checks for pcsel_top, attached through bind.
// Assumes: inputs are stable across each rising edge.
module pcsel_chk #(
    parameter int PC_W  = 22,
    parameter int REL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic             two_word_i,
    input logic [PC_W-1:0]  pc_i,
    input logic [PC_W-1:0]  imm_i,
    input logic [REL_W-1:0] rel_k_i,
    input logic [15:0]      z_i,
    input logic [PC_W-1:0]  next_pc_o,
    input logic             taken_o
);

    logic [PC_W-1:0] rel_exp;
    logic [PC_W-1:0] seq_exp;
    logic [PC_W-1:0] z_exp;

    // Independent arithmetic forms of the expected targets.
    always_comb begin
        rel_exp = pc_i + PC_W'($signed(rel_k_i)) + PC_W'(1);
        seq_exp = pc_i + (two_word_i ? PC_W'(2) : PC_W'(1));
        z_exp   = PC_W'(z_i);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (next_pc_o == '0 && !taken_o));

    // R3
    abs_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd1) |=> (next_pc_o == $past(imm_i)));

    // R4
    ptr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd2) |=> (next_pc_o == $past(z_exp)));

    // R6
    rel_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd4) |=> (next_pc_o == $past(rel_exp)));

    // R7
    seq_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0) |=> (next_pc_o == $past(seq_exp)));

    // R9
    taken_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i inside {3'd1, 3'd2, 3'd3, 3'd4}) |=> taken_o);

    // R9
    taken_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i inside {3'd0, 3'd5, 3'd6, 3'd7}) |=> !taken_o);

endmodule

bind pcsel_top pcsel_chk #(.PC_W(PC_W), .REL_W(REL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .two_word_i (two_word_i),
    .pc_i       (pc_i),
    .imm_i      (imm_i),
    .rel_k_i    (rel_k_i),
    .z_i        (z_i),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o)
);

// File: tb/sim_pcsel_top.sv
// Bench for pcsel_top: a behavioural reference model, compared every cycle.
module sim_pcsel_top;

    localparam int  PC_W  = 22;
    localparam int  REL_W = 12;
    localparam int  EXT_W = 8;
    localparam longint MOD = longint'(1) << PC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode = 3'd0;
    logic              tw = 1'b0;
    logic [PC_W-1:0]   pc = '0;
    logic [PC_W-1:0]   imm = '0;
    logic [REL_W-1:0]  k = '0;
    logic [15:0]       z = '0;
    logic [EXT_W-1:0]  ext = '0;
    logic [PC_W-1:0]   npc0, npc1;
    logic              tk0, tk1;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pcsel_top #(.PC_W(PC_W), .REL_W(REL_W), .EXT_W(EXT_W), .HAS_EXT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .two_word_i(tw), .pc_i(pc),
        .imm_i(imm), .rel_k_i(k), .z_i(z), .ext_i(ext),
        .next_pc_o(npc0), .taken_o(tk0)
    );

    pcsel_top #(.PC_W(PC_W), .REL_W(REL_W), .EXT_W(EXT_W), .HAS_EXT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .two_word_i(tw), .pc_i(pc),
        .imm_i(imm), .rel_k_i(k), .z_i(z), .ext_i(ext),
        .next_pc_o(npc1), .taken_o(tk1)
    );

    // Reference target for the current inputs.
    function automatic longint ref_pc(input bit ext_on);
        longint ks = longint'(k);
        longint r;
        if (ks >= 2048) ks = ks - 4096;
        case (mode)
            3'd1: r = longint'(imm);
            3'd2: r = longint'(z);
            3'd3: r = ext_on ? longint'(ext) * 65536 + longint'(z) : longint'(z);
            3'd4: r = longint'(pc) + ks + 1;
            default: r = longint'(pc) + (tw ? 2 : 1);
        endcase
        return ((r % MOD) + MOD) % MOD;
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5/R11";
            3'd4: return "R6";
            3'd0: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present inputs at a falling edge; compare one cycle later (R2).
    task automatic step(input logic [2:0] m, input logic [PC_W-1:0] p,
                        input logic [PC_W-1:0] im, input logic [REL_W-1:0] kk,
                        input logic [15:0] zz, input logic [EXT_W-1:0] ee,
                        input logic t);
        longint e0, e1, et;
        string  tg;
        mode = m; pc = p; imm = im; k = kk; z = zz; ext = ee; tw = t;
        e0 = ref_pc(1'b1);
        e1 = ref_pc(1'b0);
        et = (m >= 3'd1 && m <= 3'd4) ? 1 : 0;
        tg = tag_of(m);
        @(negedge clk);
        chk({tg, " R2 R8 R10 next_pc"}, longint'(npc0), e0);
        chk({tg, " R9 taken"}, longint'(tk0), et);
        chk({tg, " R11 no-ext next_pc"}, longint'(npc1), e1);
    endtask

    initial begin
        #(8 * 5000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        mode = 3'd1; imm = 22'h3ABCDE;
        @(negedge clk); @(negedge clk);
        // R1: reset forces zero despite an absolute request
        chk("R1 reset next_pc", longint'(npc0), 0);
        chk("R1 reset taken", longint'(tk0), 0);
        rst_n = 1'b1;
        // R7 sequential, one and two words
        step(3'd0, 22'h000100, '0, '0, '0, '0, 1'b0);
        step(3'd0, 22'h000100, '0, '0, '0, '0, 1'b1);
        // R8 wrap on sequential at the top of the space
        step(3'd0, 22'h3FFFFF, '0, '0, '0, '0, 1'b0);
        step(3'd0, 22'h3FFFFE, '0, '0, '0, '0, 1'b1);
        // R3 absolute; R10 two_word ignored
        step(3'd1, 22'h001234, 22'h2F0F0F, '0, '0, '0, 1'b1);
        // R4 pointer
        step(3'd2, 22'h000010, '0, '0, 16'hBEEF, 8'hFF, 1'b1);
        // R5 extended pointer, upper extension bits dropped; R11 on u1
        step(3'd3, 22'h000010, '0, '0, 16'h1357, 8'hC5, 1'b0);
        step(3'd3, 22'h000010, '0, '0, 16'hFFFF, 8'h3F, 1'b1);
        // R6 relative at both offset limits and zero
        step(3'd4, 22'h001000, '0, 12'h800, '0, '0, 1'b0);
        step(3'd4, 22'h001000, '0, 12'h7FF, '0, '0, 1'b1);
        step(3'd4, 22'h001000, '0, 12'hFFF, '0, '0, 1'b0);
        // R8 relative wrap below zero and above the top
        step(3'd4, 22'h000005, '0, 12'h800, '0, '0, 1'b0);
        step(3'd4, 22'h3FFF00, '0, 12'h7FF, '0, '0, 1'b0);
        // R9 unassigned codes behave as sequential
        step(3'd5, 22'h000200, 22'h111111, 12'h123, 16'h4444, 8'h01, 1'b0);
        step(3'd6, 22'h000200, 22'h111111, 12'h123, 16'h4444, 8'h01, 1'b1);
        step(3'd7, 22'h3FFFFF, 22'h111111, 12'h123, 16'h4444, 8'h01, 1'b1);
        // R1 reset in mid-run
        rst_n = 1'b0; mode = 3'd4;
        @(negedge clk);
        chk("R1 mid-run reset next_pc", longint'(npc0), 0);
        chk("R1 mid-run reset taken", longint'(tk0), 0);
        rst_n = 1'b1;
        // Mixed random traffic over all codes
        for (int i = 0; i < 400; i++) begin
            step(3'($urandom_range(0, 7)), PC_W'($urandom), PC_W'($urandom),
                 REL_W'($urandom), 16'($urandom), EXT_W'($urandom), 1'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule